// File: doc/BRIEF.md
# Run-Time Selectable Branch Direction Predictor

This block answers one question for a fetch stage: will the conditional branch at a given address be taken? A 3-bit mode input picks the rule used to answer it. There are three fixed rules and two learning rules. The fixed rules are never taken, always taken, and a rule that predicts taken for branches whose offset is negative (loop-closing) and not taken for forward branches. The learning rules keep one small table per scheme, each indexed directly by low address bits. One table holds the last outcome seen for each entry. The other holds a saturating 2-bit counter that changes its prediction only after two misses in a row.

The lookup side is purely combinational: the branch address and a backward flag go in, and a taken bit comes out in the same cycle. The update side takes the address of a resolved branch and its real outcome. The update is written at the next rising clock edge, and only into the table of the mode that is active. Under a fixed rule, and under unused mode codes, updates are dropped. Because there are no tags, branches whose low address bits match share one entry.

Top module: `bp_dir_predictor`

## Requirements
- R1: Mode codes are 0 never-taken, 1 always-taken, 2 backward-taken, 3 last-outcome and 4 two-bit. In modes 0 to 2 an update leaves both tables unchanged, and the prediction depends only on the mode and the backward flag.
- R2: In mode 0 the prediction is 0. In mode 1 the prediction is 1.
- R3: In mode 2 the prediction equals `lk_backward_i`, where 1 means a negative branch offset.
- R4: In mode 3 each entry holds the outcome of the last update to it (1 taken, 0 not taken), and that bit is the prediction.
- R5: In mode 4 each entry is a 2-bit counter: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken update increments it and a not-taken update decrements it, with saturation at 11 and 00. The prediction is bit 1.
- R6: In mode 4 a single miss from a strong state does not change the prediction. Two consecutive misses do.
- R7: Both tables have 64 entries selected by address bits [7:2]. Two addresses that agree in those bits share an entry.
- R8: After reset, every last-outcome entry is 0 and every counter is 01.
- R9: A lookup is combinational. When it hits the entry being updated in the same cycle, it returns the state from before the update. The new state is visible from the next cycle.
- R10: An update changes only the table of the active learning mode. Mode codes 5 to 7 predict 0 and ignore updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Prediction rule select |
| lk_pc_i | input | 32 | Address of the branch being predicted |
| lk_backward_i | input | 1 | 1 when the branch offset is negative |
| upd_valid_i | input | 1 | A resolved outcome is presented |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| pred_taken_o | output | 1 | Predicted direction |

## Verification
A prediction is due in the same cycle as its lookup inputs, with zero register stages. An update becomes visible to lookups from the cycle after the clock edge that captures it. The bench drives each vector just after a falling edge and samples `pred_taken_o` one nanosecond later, before the next rising edge. As a result, each expected value reflects every update captured at earlier edges and never the update presented alongside the lookup. The two same-cycle vectors rely on exactly that ordering to confirm that the old state is returned.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NEVER = 3'd0,
    MODE_ALWAYS = 3'd1,
    MODE_BACKWARD = 3'd2,
    MODE_LAST = 3'd3,
    MODE_HYST = 3'd4
  } bp_mode_e;

  localparam logic [1:0] HYST_RESET = 2'b01;
  localparam logic LAST_RESET = 1'b0;
endpackage

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic unused_pc;

  assign idx_o     = pc_i[IDX_LSB +: IDX_W];
  assign unused_pc = ^pc_i;
endmodule

// File: rtl/bp_static_rule.sv
module bp_static_rule
  import bp_pkg::*;
(
  input  bp_mode_e mode_i,
  input  logic     backward_i,
  output logic     taken_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ALWAYS:   taken_o = 1'b1;
      MODE_BACKWARD: taken_o = backward_i;
      default:       taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_state_table.sv
module bp_state_table #(
  parameter int               IDX_W     = 6,
  parameter int               ENTRY_W   = 2,
  parameter logic [ENTRY_W-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_pred_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ENTRY_W-1:0] SAT_HI = '1;
  localparam logic [ENTRY_W-1:0] SAT_LO = '0;

  logic [ENTRY_W-1:0] ent_q [ENTRIES];
  logic [ENTRY_W-1:0] ent_cur;
  logic [ENTRY_W-1:0] ent_d;

  assign ent_cur   = ent_q[wr_idx_i];
  assign rd_pred_o = ent_q[rd_idx_i][ENTRY_W-1];

  if (ENTRY_W == 1) begin : g_last
    assign ent_d = wr_taken_i;
  end else begin : g_sat
    always_comb begin
      ent_d = ent_cur;
      if (wr_taken_i && ent_cur != SAT_HI) ent_d = ent_cur + 1'b1;
      else if (!wr_taken_i && ent_cur != SAT_LO) ent_d = ent_cur - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) ent_q[e] <= RESET_VAL;
    end else if (we_i) begin
      ent_q[wr_idx_i] <= ent_d;
    end
  end
endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic              lk_backward_i,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  output logic              pred_taken_o
);
  bp_mode_e         mode;
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic             last_we, hyst_we;
  logic             last_pred, hyst_pred, static_pred;

  assign mode    = bp_mode_e'(mode_i);
  assign last_we = upd_valid_i && (mode == MODE_LAST);
  assign hyst_we = upd_valid_i && (mode == MODE_HYST);

  bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_lk_index (
    .pc_i (lk_pc_i),
    .idx_o(lk_idx)
  );

  bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_upd_index (
    .pc_i (upd_pc_i),
    .idx_o(upd_idx)
  );

  bp_state_table #(.IDX_W(IDX_W), .ENTRY_W(1), .RESET_VAL(LAST_RESET)) i_last_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lk_idx),
    .rd_pred_o (last_pred),
    .we_i      (last_we),
    .wr_idx_i  (upd_idx),
    .wr_taken_i(upd_taken_i)
  );

  bp_state_table #(.IDX_W(IDX_W), .ENTRY_W(2), .RESET_VAL(HYST_RESET)) i_hyst_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lk_idx),
    .rd_pred_o (hyst_pred),
    .we_i      (hyst_we),
    .wr_idx_i  (upd_idx),
    .wr_taken_i(upd_taken_i)
  );

  bp_static_rule i_static_rule (
    .mode_i    (mode),
    .backward_i(lk_backward_i),
    .taken_o   (static_pred)
  );

  always_comb begin
    unique case (mode)
      MODE_LAST: pred_taken_o = last_pred;
      MODE_HYST: pred_taken_o = hyst_pred;
      default:   pred_taken_o = static_pred;
    endcase
  end
endmodule

// File: rtl/bp_dir_checker.sv
module bp_dir_checker #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      mode_i,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_backward_i,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic            upd_taken_i,
  input logic            pred_taken_o
);
  logic [1:0]       cyc_q;
  logic [IDX_W-1:0] lk_idx, upd_idx;

  assign lk_idx  = lk_pc_i[IDX_LSB +: IDX_W];
  assign upd_idx = upd_pc_i[IDX_LSB +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_never_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |-> !pred_taken_o);

  p_always_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1) |-> pred_taken_o);

  p_backward_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2) |-> (pred_taken_o == lk_backward_i));

  p_unused_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 3'd4) |-> !pred_taken_o);

  p_last_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && mode_i == 3'd3 && $past(mode_i) == 3'd3 && $past(upd_valid_i)
     && $past(upd_idx) == lk_idx) |-> (pred_taken_o == $past(upd_taken_i)));

  p_two_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && mode_i == 3'd4 && $past(mode_i) == 3'd4 && $past(mode_i, 2) == 3'd4
     && $past(upd_valid_i) && $past(upd_valid_i, 2)
     && $past(upd_idx) == lk_idx && $past(upd_idx, 2) == lk_idx
     && $past(upd_taken_i) && $past(upd_taken_i, 2)) |-> pred_taken_o);

  p_two_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && mode_i == 3'd4 && $past(mode_i) == 3'd4 && $past(mode_i, 2) == 3'd4
     && $past(upd_valid_i) && $past(upd_valid_i, 2)
     && $past(upd_idx) == lk_idx && $past(upd_idx, 2) == lk_idx
     && !$past(upd_taken_i) && !$past(upd_taken_i, 2)) |-> !pred_taken_o);
endmodule

bind bp_dir_predictor bp_dir_checker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)
) i_bp_dir_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .lk_pc_i      (lk_pc_i),
  .lk_backward_i(lk_backward_i),
  .upd_valid_i  (upd_valid_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .pred_taken_o (pred_taken_o)
);

// File: tb/test_bp_dir_predictor.sv
`timescale 1ns/1ps
module test_bp_dir_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_backward_i = 1'b0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic        pred_taken_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bp_dir_predictor i_bp_dir_predictor (.*);

  // {mode, lk_pc, backward, upd_valid, upd_pc, upd_taken, expected, req}
  localparam int NV = 24;
  localparam logic [42:0] VECS [NV] = '{
    {3'd0, 16'h0104, 1'b1, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd1},  // R1 R2 never, update ignored
    {3'd1, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd2},  // R2 always
    {3'd2, 16'h0104, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd3},  // R3 backward
    {3'd2, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd3},  // R3 forward
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd1},  // R1 R8 still 01 -> 10
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd9},  // R9 old state read, -> 01
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd9},  // R9 new state seen, -> 10
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b1, 4'd5},  // R5 -> 11
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd5},  // R5 at 11, -> 10
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd6},  // R6 one miss keeps taken, -> 01
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b0, 4'd6},  // R6 flipped after two, -> 00
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b0, 4'd5},  // R5 saturate at 00
    {3'd4, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd5},  // R5 00 -> 01
    {3'd4, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 one hit from strong NT keeps NT
    {3'd4, 16'h0504, 1'b0, 1'b1, 16'h0504, 1'b1, 1'b0, 4'd7},  // R7 alias entry 1, -> 10
    {3'd4, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd7},  // R7 alias shares state
    {3'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd10}, // R10 1-bit untouched by mode 4
    {3'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b0, 1'b1, 4'd4},  // R4 last taken
    {3'd3, 16'h0104, 1'b0, 1'b1, 16'h0104, 1'b1, 1'b0, 4'd4},  // R4 last not taken
    {3'd3, 16'h0108, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 other entry untouched
    {3'd4, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd10}, // R10 counter untouched by mode 3
    {3'd5, 16'h0104, 1'b1, 1'b1, 16'h0104, 1'b0, 1'b0, 4'd10}, // R10 unused code
    {3'd4, 16'h0104, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd10}, // R10 update was ignored
    {3'd2, 16'h01F8, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd3}   // R3
  };

  task automatic check(input logic exp, input int req, input string what);
    n_checks++;
    if (pred_taken_o !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, pred_taken_o, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [31:0] lpc, input logic bw,
                       input logic uv, input logic [31:0] upc, input logic ut);
    @(negedge clk_i);
    mode_i = m; lk_pc_i = lpc; lk_backward_i = bw;
    upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(1'b0, 8, "reset mode 0 output");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][42:40], {16'h0, VECS[i][39:24]}, VECS[i][23],
            VECS[i][22], {16'h0, VECS[i][21:6]}, VECS[i][5]);
      check(VECS[i][4], int'(VECS[i][3:0]), $sformatf("vector %0d", i));
    end

    // R8: reset restores weak not-taken counters and zero outcome bits
    drive(3'd4, 32'h0104, 1'b0, 1'b0, 32'h0, 1'b0);
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    #0.5;
    check(1'b0, 8, "counter reset");
    drive(3'd4, 32'h010C, 1'b0, 1'b1, 32'h010C, 1'b1);
    check(1'b0, 8, "reset counter predicts not taken");
    drive(3'd4, 32'h010C, 1'b0, 1'b0, 32'h0, 1'b0);
    check(1'b1, 8, "one taken from reset flips (weak)");
    drive(3'd3, 32'h0104, 1'b0, 1'b0, 32'h0, 1'b0);
    check(1'b0, 8, "outcome bit reset");

    // R7: top entry 63 via bits [7:2]
    drive(3'd3, 32'hFFFF_00FC, 1'b0, 1'b1, 32'h0000_00FC, 1'b1);
    check(1'b0, 7, "entry 63 before update");
    drive(3'd3, 32'h1234_00FC, 1'b0, 1'b0, 32'h0, 1'b0);
    check(1'b1, 7, "entry 63 after update, high bits ignored");
    drive(3'd3, 32'h0000_00F8, 1'b0, 1'b0, 32'h0, 1'b0);
    check(1'b0, 7, "entry 62 untouched");

    // R1: static update with mode 1 then read in mode 3
    drive(3'd1, 32'h0110, 1'b0, 1'b1, 32'h0110, 1'b1);
    check(1'b1, 1, "always-taken");
    drive(3'd3, 32'h0110, 1'b0, 1'b0, 32'h0, 1'b0);
    check(1'b0, 1, "static update left table");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule